// File: doc/BRIEF.md
# Vector Even/Odd Unzip Permute Unit

This unit gathers every other element from two source vectors and packs them into one destination vector. The vector length `VL` is fixed at build time and must be a multiple of 128 bits. The element width is chosen per operation and can be 8, 16, 32, 64 or 128 bits. A parity select picks either the even-numbered or the odd-numbered elements. The elements taken from the first source fill the low part of the destination in ascending order. The elements taken from the second source follow directly above them.

The unit also decodes a 32-bit instruction word. From it the unit extracts the three register indices, the element width and the parity. A word that matches neither accepted pattern is reported as undefined. An operation whose element width is too wide to form even one pair at the configured `VL` is also reported as undefined. Each result is registered with one cycle of latency. The operands arrive on their own ports, because register-file access happens outside this unit.

When the even parity is used, the operation behaves like cutting each double-width element of both sources down to its low half and packing the halves into a single vector.

Top module: `vec_unzip_unit`

## Requirements
- R1: A word with bits 31:24 = 8'b00000101, bit 21 = 1 and bits 15:11 = 5'b01101 is accepted. Its element width is 8 << bits 23:22, and bit 10 selects odd parity (1) or even parity (0).
- R2: A word with bits 31:21 = 11'b00000101101 and bits 15:11 = 5'b00001 is accepted with a 128-bit element width, and bit 10 selects parity.
- R3: A word that matches neither R1 nor R2 drives `out_undef` high one cycle later. `result` and the index outputs keep their previous values.
- R4: After an accepted operation, `dst_idx`, `srca_idx` and `srcb_idx` carry bits 4:0, 9:5 and 20:16 of that word.
- R5: With pairs = VL / (2·esize), destination element p (0 ≤ p < pairs) equals element 2p+parity of `src_a`.
- R6: Destination element pairs+p equals element 2p+parity of `src_b`.
- R7: When VL < 2·esize (the 128-bit width at VL = 128), `out_undef` is raised and `result` is held.
- R8: Destination bits above 2·pairs·esize are zero, for example the top 128 bits for the 128-bit width at VL = 384.
- R9: `out_valid` follows `in_valid` with one cycle of latency, and `out_undef` is high only while `out_valid` is high.
- R10: While `in_valid` is low, `result` and the index outputs do not change.
- R11: With even parity, each destination element equals the low half of the corresponding double-width source element.
- R12: After reset, `out_valid`, `out_undef`, `result` and all index outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| insn | input | 32 | Instruction word |
| src_a | input | VL | First source vector |
| src_b | input | VL | Second source vector |
| out_valid | output | 1 | A registered outcome is present |
| out_undef | output | 1 | The operation was undefined |
| dst_idx | output | 5 | Destination register index |
| srca_idx | output | 5 | First source register index |
| srcb_idx | output | 5 | Second source register index |
| result | output | VL | Packed destination vector |

## Verification
The two conditions that are hard to reach are the undefined-by-length case and the partially covered destination. Neither can occur at the widths used most often. The bench therefore drives one identical stimulus stream into four copies of the unit, built at VL = 128, 256, 384 and 512. With that setup, the 128-bit width is undefined in one copy and leaves 128 uncovered bits in another, all within the same cycle. Undefined and idle cycles are placed directly after accepted operations, with fresh random operands, so that any leak of new data into the held result shows up.

// File: rtl/vu_pkg.sv
package vu_pkg;
    localparam int NUM_SIZES = 5;

    typedef enum logic [1:0] {
        ENC_NONE,
        ENC_SIZED,
        ENC_QUAD
    } enc_class_e;

    typedef struct packed {
        enc_class_e cls;
        logic [2:0] sz_log;
        logic       odd;
        logic [4:0] rd;
        logic [4:0] rn;
        logic [4:0] rm;
    } dec_t;
endpackage

// File: rtl/vu_decoder.sv
module vu_decoder
    import vu_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);
    logic sized_hit;
    logic quad_hit;

    assign sized_hit = (insn[31:24] == 8'b0000_0101) && insn[21] &&
                       (insn[15:11] == 5'b01101);
    assign quad_hit  = (insn[31:21] == 11'b000_0010_1101) &&
                       (insn[15:11] == 5'b00001);

    always_comb begin
        dec        = '0;
        dec.cls    = ENC_NONE;
        dec.rd     = insn[4:0];
        dec.rn     = insn[9:5];
        dec.rm     = insn[20:16];
        dec.odd    = insn[10];
        if (sized_hit) begin
            dec.cls    = ENC_SIZED;
            dec.sz_log = {1'b0, insn[23:22]};
        end else if (quad_hit) begin
            dec.cls    = ENC_QUAD;
            dec.sz_log = 3'd4;
        end
    end
endmodule

// File: rtl/vu_permute.sv
module vu_permute
    import vu_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic [VL-1:0] src_a,
    input  logic [VL-1:0] src_b,
    input  logic [2:0]    sz_log,
    input  logic          odd,
    output logic [VL-1:0] packed_out,
    output logic          too_short
);
    logic [VL-1:0]        cand [2*NUM_SIZES];
    logic [NUM_SIZES-1:0] fits;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int ES    = 8 << g;
        localparam int PAIRS = VL / (2 * ES);
        localparam int USED  = 2 * PAIRS * ES;
        logic [VL-1:0] ev;
        logic [VL-1:0] od;
        if (PAIRS > 0) begin : g_ok
            for (genvar p = 0; p < PAIRS; p++) begin : g_pair
                assign ev[p*ES +: ES]         = src_a[(2*p)*ES +: ES];
                assign ev[(PAIRS+p)*ES +: ES] = src_b[(2*p)*ES +: ES];
                assign od[p*ES +: ES]         = src_a[(2*p+1)*ES +: ES];
                assign od[(PAIRS+p)*ES +: ES] = src_b[(2*p+1)*ES +: ES];
            end
            if (USED < VL) begin : g_pad
                assign ev[VL-1:USED] = '0;
                assign od[VL-1:USED] = '0;
            end
            assign fits[g] = 1'b1;
        end else begin : g_none
            assign ev      = '0;
            assign od      = '0;
            assign fits[g] = 1'b0;
        end
        assign cand[2*g]   = ev;
        assign cand[2*g+1] = od;
    end

    always_comb begin
        packed_out = '0;
        too_short  = 1'b1;
        unique case (sz_log)
            3'd0: begin packed_out = odd ? cand[1] : cand[0]; too_short = !fits[0]; end
            3'd1: begin packed_out = odd ? cand[3] : cand[2]; too_short = !fits[1]; end
            3'd2: begin packed_out = odd ? cand[5] : cand[4]; too_short = !fits[2]; end
            3'd3: begin packed_out = odd ? cand[7] : cand[6]; too_short = !fits[3]; end
            3'd4: begin packed_out = odd ? cand[9] : cand[8]; too_short = !fits[4]; end
            default: begin packed_out = '0; too_short = 1'b1; end
        endcase
    end
endmodule

// File: rtl/vec_unzip_unit.sv
module vec_unzip_unit
    import vu_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [31:0]   insn,
    input  logic [VL-1:0] src_a,
    input  logic [VL-1:0] src_b,
    output logic          out_valid,
    output logic          out_undef,
    output logic [4:0]    dst_idx,
    output logic [4:0]    srca_idx,
    output logic [4:0]    srcb_idx,
    output logic [VL-1:0] result
);
    dec_t          dec;
    logic [VL-1:0] perm;
    logic          too_short;
    logic          known;
    logic          undef;
    logic          accept;

    vu_decoder u_dec (
        .insn (insn),
        .dec  (dec)
    );

    vu_permute #(.VL(VL)) u_perm (
        .src_a      (src_a),
        .src_b      (src_b),
        .sz_log     (dec.sz_log),
        .odd        (dec.odd),
        .packed_out (perm),
        .too_short  (too_short)
    );

    always_comb begin
        unique case (dec.cls)
            ENC_SIZED: known = 1'b1;
            ENC_QUAD:  known = 1'b1;
            ENC_NONE:  known = 1'b0;
            default:   known = 1'b0;
        endcase
        undef  = !known || too_short;
        accept = in_valid && !undef;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_undef <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_undef <= in_valid && undef;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            dst_idx  <= '0;
            srca_idx <= '0;
            srcb_idx <= '0;
        end else if (accept) begin
            result   <= perm;
            dst_idx  <= dec.rd;
            srca_idx <= dec.rn;
            srcb_idx <= dec.rm;
        end
    end
endmodule

// File: rtl/vu_unzip_checker.sv
module vu_unzip_checker #(
    parameter int VL = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [31:0]   insn,
    input logic          out_valid,
    input logic          out_undef,
    input logic [4:0]    dst_idx,
    input logic [4:0]    srca_idx,
    input logic [4:0]    srcb_idx,
    input logic [VL-1:0] result
);
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_undef_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> out_valid);
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(dst_idx) &&
                       $stable(srca_idx) && $stable(srcb_idx)));
    p_undef_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> ($stable(result) && $stable(dst_idx)));
    p_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_undef) |->
        (dst_idx == $past(insn[4:0]) && srca_idx == $past(insn[9:5]) &&
         srcb_idx == $past(insn[20:16])));
    if (VL < 256) begin : g_narrow
        p_quad_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && insn[31:21] == 11'b000_0010_1101 &&
             insn[15:11] == 5'b00001) |=> out_undef);
    end
endmodule

bind vec_unzip_unit vu_unzip_checker #(.VL(VL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .insn      (insn),
    .out_valid (out_valid),
    .out_undef (out_undef),
    .dst_idx   (dst_idx),
    .srca_idx  (srca_idx),
    .srcb_idx  (srcb_idx),
    .result    (result)
);

// File: tb/vec_unzip_unit_test.sv
`timescale 1ns/1ps
module vec_unzip_unit_test;
    localparam int W = 512;
    localparam int NL = 4;
    localparam int LVL [NL] = '{256, 128, 384, 512};

    typedef struct packed {
        logic [NL-1:0]         undef;
        logic [NL-1:0][W-1:0]  res;
        logic [NL-1:0][14:0]   idx;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;

    logic [NL-1:0]   ov, ou;
    logic [4:0]      rd_o [NL];
    logic [4:0]      rn_o [NL];
    logic [4:0]      rm_o [NL];
    logic [255:0]    r0;
    logic [127:0]    r1;
    logic [383:0]    r2;
    logic [511:0]    r3;
    logic [W-1:0]    got [NL];

    int checks = 0;
    int fails  = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    exp_t q [$];
    logic [W-1:0] model_res [NL];
    logic [14:0]  model_idx [NL];
    logic [W-1:0] seen_res [NL];
    logic [14:0]  seen_idx [NL];

    always #4 clk = ~clk;

    vec_unzip_unit #(.VL(256)) uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .insn(insn), .src_a(a_in[255:0]), .src_b(b_in[255:0]), .out_valid(ov[0]),
        .out_undef(ou[0]), .dst_idx(rd_o[0]), .srca_idx(rn_o[0]), .srcb_idx(rm_o[0]),
        .result(r0));
    vec_unzip_unit #(.VL(128)) uut_n (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .insn(insn), .src_a(a_in[127:0]), .src_b(b_in[127:0]), .out_valid(ov[1]),
        .out_undef(ou[1]), .dst_idx(rd_o[1]), .srca_idx(rn_o[1]), .srcb_idx(rm_o[1]),
        .result(r1));
    vec_unzip_unit #(.VL(384)) uut_m (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .insn(insn), .src_a(a_in[383:0]), .src_b(b_in[383:0]), .out_valid(ov[2]),
        .out_undef(ou[2]), .dst_idx(rd_o[2]), .srca_idx(rn_o[2]), .srcb_idx(rm_o[2]),
        .result(r2));
    vec_unzip_unit #(.VL(512)) uut_w (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .insn(insn), .src_a(a_in), .src_b(b_in), .out_valid(ov[3]),
        .out_undef(ou[3]), .dst_idx(rd_o[3]), .srca_idx(rn_o[3]), .srcb_idx(rm_o[3]),
        .result(r3));

    assign got[0] = W'(r0);
    assign got[1] = W'(r1);
    assign got[2] = W'(r2);
    assign got[3] = r3;

    function automatic logic [31:0] enc_sized(input logic [1:0] sz, input logic odd,
                                              input logic [4:0] rd, rn, rm);
        return {8'b0000_0101, sz, 1'b1, rm, 5'b01101, odd, rn, rd};
    endfunction

    function automatic logic [31:0] enc_quad(input logic odd, input logic [4:0] rd, rn, rm);
        return {11'b000_0010_1101, rm, 5'b00001, odd, rn, rd};
    endfunction

    // Expected element gather, from R5, R6 and R8
    function automatic logic [W-1:0] ref_unzip(input logic [W-1:0] a, b,
                                               input int vl, es, part);
        logic [W-1:0] r = '0;
        int pairs = vl / (2 * es);
        for (int p = 0; p < pairs; p++)
            for (int k = 0; k < es; k++) begin
                r[p*es + k]         = a[(2*p+part)*es + k];
                r[(pairs+p)*es + k] = b[(2*p+part)*es + k];
            end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [W-1:0] a, b);
        exp_t e;
        int es;
        bit known;
        @(negedge clk);
        in_valid = 1'b1; insn = w; a_in = a; b_in = b;
        known = 1'b0; es = 0;
        if (w[31:24] == 8'b0000_0101 && w[21] && w[15:11] == 5'b01101) begin
            known = 1'b1; es = 8 << w[23:22];          // R1
        end else if (w[31:21] == 11'b000_0010_1101 && w[15:11] == 5'b00001) begin
            known = 1'b1; es = 128;                    // R2
        end
        for (int l = 0; l < NL; l++) begin
            e.undef[l] = !known || (LVL[l] < 2 * es);  // R3, R7
            if (!e.undef[l]) begin
                model_res[l] = ref_unzip(a, b, LVL[l], es, int'(w[10]));
                model_idx[l] = {w[20:16], w[9:5], w[4:0]};
            end
            e.res[l] = model_res[l];
            e.idx[l] = model_idx[l];
        end
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        insn = $urandom;
        a_in = {16{$urandom}};
        b_in = {16{$urandom}};
    endtask

    function automatic logic [W-1:0] rnd_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (ov[0]) begin
                    exp_t e;
                    if (q.size() == 0) begin
                        check(1'b0, "R9 queue", W'(0), W'(1));
                    end else begin
                        e = q.pop_front();
                        for (int l = 0; l < NL; l++) begin
                            check(ov[l] == 1'b1, "R9 valid", W'(ov[l]), W'(1));
                            check(ou[l] == e.undef[l], "R3/R7 undef", W'(ou[l]), W'(e.undef[l]));
                            check(got[l] == e.res[l], "R5/R6/R8 result", got[l], e.res[l]);
                            check({rm_o[l], rn_o[l], rd_o[l]} == e.idx[l], "R4 indices",
                                  W'({rm_o[l], rn_o[l], rd_o[l]}), W'(e.idx[l]));
                            seen_res[l] = e.res[l];
                            seen_idx[l] = e.idx[l];
                        end
                    end
                end else begin
                    for (int l = 0; l < NL; l++) begin
                        check(ov[l] == 1'b0 && ou[l] == 1'b0, "R9 idle flags",
                              W'({ov[l], ou[l]}), W'(0));
                        check(got[l] == seen_res[l], "R10 hold result", got[l], seen_res[l]);
                        check({rm_o[l], rn_o[l], rd_o[l]} == seen_idx[l], "R10 hold indices",
                              W'({rm_o[l], rn_o[l], rd_o[l]}), W'(seen_idx[l]));
                    end
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a, b;
        for (int l = 0; l < NL; l++) begin
            model_res[l] = '0; model_idx[l] = '0; seen_res[l] = '0; seen_idx[l] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        for (int l = 0; l < NL; l++) begin
            check(ov[l] == 0 && ou[l] == 0, "R12 flags", W'({ov[l], ou[l]}), W'(0));
            check(got[l] == '0, "R12 result", got[l], '0);
            check({rm_o[l], rn_o[l], rd_o[l]} == 15'd0, "R12 indices",
                  W'({rm_o[l], rn_o[l], rd_o[l]}), W'(0));
        end
        mon_on = 1'b1;

        // R1, R5, R6: every normal width and parity
        for (int rep = 0; rep < 3; rep++)
            for (int s = 0; s < 4; s++)
                for (int par = 0; par < 2; par++) begin
                    apply(enc_sized(2'(s), 1'(par), 5'($urandom), 5'($urandom), 5'($urandom)),
                          rnd_vec(), rnd_vec());
                    if (rep == 1) idle();
                end

        // R2, R7, R8: 128-bit elements, both parities
        for (int rep = 0; rep < 3; rep++)
            for (int par = 0; par < 2; par++) begin
                apply(enc_quad(1'(par), 5'($urandom), 5'($urandom), 5'($urandom)),
                      rnd_vec(), rnd_vec());
                idle();
            end

        // R3: near-miss words right after accepted ones
        apply(enc_sized(2'd1, 1'b0, 5'd3, 5'd4, 5'd5), rnd_vec(), rnd_vec());
        apply(enc_sized(2'd1, 1'b0, 5'd3, 5'd4, 5'd5) ^ 32'h0020_0000, rnd_vec(), rnd_vec());
        apply(enc_sized(2'd2, 1'b1, 5'd6, 5'd7, 5'd8) ^ 32'h0000_1000, rnd_vec(), rnd_vec());
        apply(enc_quad(1'b0, 5'd9, 5'd10, 5'd11) ^ 32'h8000_0000, rnd_vec(), rnd_vec());
        apply(32'h0, rnd_vec(), rnd_vec());
        idle();

        // R11: even parity equals truncation of double-width elements
        a = rnd_vec(); b = rnd_vec();
        apply(enc_sized(2'd0, 1'b0, 5'd1, 5'd2, 5'd3), a, b);
        idle();
        for (int p = 0; p < 16; p++) begin
            check(r0[p*8 +: 8] == a[p*16 +: 8], "R11 low half",
                  W'(r0[p*8 +: 8]), W'(a[p*16 +: 8]));
            check(r0[(16+p)*8 +: 8] == b[p*16 +: 8], "R11 high half",
                  W'(r0[(16+p)*8 +: 8]), W'(b[p*16 +: 8]));
        end

        // back-to-back mixed stream
        for (int i = 0; i < 40; i++) begin
            logic [31:0] w;
            case (i % 3)
                0: w = enc_sized(2'($urandom), 1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
                1: w = enc_quad(1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
                default: w = $urandom;
            endcase
            apply(w, rnd_vec(), rnd_vec());
        end
        idle();
        repeat (3) idle();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule